// File: doc/BRIEF.md
# System control register file

This block is a bank of 32-bit configuration and status words that sit in a 4 KiB address window of a chip's peripheral space. A bus master reaches it through a simple select/write/address/data port. Each access takes one cycle. Read data is registered and shows up on the cycle after the address. Every word follows one access policy:

- plain storage
- read-only
- write-1-to-clear, where the new value is the old value with the written ones cleared
- write-1-to-set, where the new value is the old value with the written ones added, so software can never clear a bit

Most words load a fixed constant on cold reset. Three words take their reset value from inputs that are sampled while reset is held:

- the power-on strap word
- the disabled-modules word
- a DRAM size code that is folded into a memory-map word

Offsets past the last implemented word read as zero and ignore writes. A one-cycle error pulse flags such accesses, and it also flags writes to read-only words. The pulse is diagnostic only.

Top module: `sysctl_regfile`

## Requirements
- R1: A read presented in cycle n returns its data on `rdata_o` from cycle n+1, and `rdata_o` holds between reads. A read of a word offset at or above 0x148 returns 0.
- R2: A write to a word offset at or above 0x148 changes no register.
- R3: Writes to offsets 0x000, 0x004 and 0x040 have no effect.
- R4: At offsets 0x06C and 0x0D4, a write stores old AND NOT write data.
- R5: At offsets 0x070 and 0x07C, a write stores old OR write data, so no bit there can be cleared by a write.
- R6: Reset loads the following values. Every other offset below 0x148 that R7 and R8 do not name resets to 0.

  | Offset | Reset value |
  |---|---|
  | 0x000 | 0x04A92750 |
  | 0x010 | 0x0000FFFF |
  | 0x038 | 0x00000003 |
  | 0x03C | 0x0000035E |
  | 0x050 | 0x0000004E |
  | 0x060 | 0x00080000 |
  | 0x06C | 0x80000000 |
  | 0x078 | 0x000000C0 |
  | 0x098 | 0x5A00F3CF |
  | 0x13C | 0x00000008 |
  | 0x140 | 0x034730E4 |
  | 0x144 | 0x034730E4 |

- R7: While reset is held, offset 0x004 loads `strap_i` and offset 0x07C loads `mod_dis_i`.
- R8: While reset is held, offset 0x09C loads 0x00001002 OR (c << 8), where c is `dram_code_i`. A code above 4 is treated as 4.
- R9: Every other offset below 0x148, including unnamed gaps, is plain 32-bit read/write storage.
- R10: `err_o` is high in cycle n+1 exactly when the access in cycle n targeted an offset at or above 0x148, or was a write to a read-only offset. It is low after every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous cold reset |
| sel_i | input | 1 | Access request this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset in the window; bits 1:0 are ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle diagnostic pulse for a bad access |
| strap_i | input | 32 | Power-on strap word, reset value of 0x004 |
| mod_dis_i | input | 32 | Disabled-modules word, reset value of 0x07C |
| dram_code_i | input | 3 | log2(DRAM size / 128 MiB), sampled during reset |

## Verification
The bound checker watches every cycle for the following:
- the error pulse follows exactly the accesses that should raise it;
- out-of-range reads return zero;
- the read-only words never move;
- write-1-to-clear words never gain a bit;
- write-1-to-set words never lose a bit.

The exact reset constants, the strap and DRAM-code loading (including the clamp of codes 5 to 7), and the plain storage of gap offsets are shown only by the bench. It sweeps every word offset of the window after reset and after two write passes, and it repeats reset for all eight DRAM codes.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_REGS = 82;
  localparam int unsigned IDX_W    = ADDR_W - 2;

  localparam int unsigned IDX_STRAP = 1;
  localparam int unsigned IDX_MDIS  = 31;
  localparam int unsigned IDX_DRAM  = 39;
  localparam int unsigned DRAM_MAX  = 4;

  typedef enum logic [1:0] {
    ACC_RW  = 2'd0,
    ACC_RO  = 2'd1,
    ACC_W1C = 2'd2,
    ACC_W1S = 2'd3
  } acc_e;

  function automatic acc_e policy_of(input int unsigned idx);
    case (idx)
      0, 1, 16: return ACC_RO;
      27, 53:   return ACC_W1C;
      28, 31:   return ACC_W1S;
      default:  return ACC_RW;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] default_of(input int unsigned idx);
    case (idx)
      0:       return 32'h04A9_2750;
      4:       return 32'h0000_FFFF;
      14:      return 32'h0000_0003;
      15:      return 32'h0000_035E;
      20:      return 32'h0000_004E;
      24:      return 32'h0008_0000;
      27:      return 32'h8000_0000;
      30:      return 32'h0000_00C0;
      38:      return 32'h5A00_F3CF;
      79:      return 32'h0000_0008;
      80, 81:  return 32'h0347_30E4;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned NREGS = NUM_REGS
) (
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [NREGS-1:0] we_o,
  output logic             err_o
);
  logic in_range;
  logic ro_hit;

  assign in_range = (int'(idx_i) < int'(NREGS));
  assign ro_hit   = in_range && (policy_of(int'(idx_i)) == ACC_RO);
  assign err_o    = sel_i && (!in_range || (wr_i && ro_hit));

  for (genvar g = 0; g < int'(NREGS); g++) begin : g_we
    if (policy_of(g) == ACC_RO) begin : g_ro
      assign we_o[g] = 1'b0;
    end else begin : g_wr
      assign we_o[g] = sel_i && wr_i && (idx_i == IDX_W'(g));
    end
  end
endmodule

// File: rtl/sysctl_reg.sv
module sysctl_reg
  import sysctl_pkg::*;
#(
  parameter acc_e POLICY = ACC_RW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rst_val_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    case (POLICY)
      ACC_W1C: nxt = q_o & ~wdata_i;
      ACC_W1S: nxt = q_o | wdata_i;
      default: nxt = wdata_i;
    endcase
  end

  // reset value is loaded for as long as reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= rst_val_i;
    else if (we_i) q_o <= nxt;
  end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int unsigned NREGS = NUM_REGS
) (
  input  logic [NREGS-1:0][DATA_W-1:0] regs_i,
  input  logic [IDX_W-1:0]             idx_i,
  output logic [DATA_W-1:0]            data_o
);
  // indices with no register fall through to zero
  always_comb begin
    data_o = '0;
    for (int i = 0; i < int'(NREGS); i++) begin
      if (idx_i == IDX_W'(i)) data_o = regs_i[i];
    end
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  input  logic [DATA_W-1:0] strap_i,
  input  logic [DATA_W-1:0] mod_dis_i,
  input  logic [2:0]        dram_code_i
);
  logic [IDX_W-1:0]                idx;
  logic [NUM_REGS-1:0]             we;
  logic                            err_d;
  logic [DATA_W-1:0]               rd_d;
  logic [NUM_REGS-1:0][DATA_W-1:0] reg_q;
  logic [NUM_REGS-1:0][DATA_W-1:0] rst_val;
  logic [2:0]                      code_c;
  logic [DATA_W-1:0]               dram_word;
  logic                            unused_lsb;

  assign idx        = addr_i[ADDR_W-1:2];
  assign unused_lsb = ^addr_i[1:0];

  assign code_c    = (dram_code_i > 3'(DRAM_MAX)) ? 3'(DRAM_MAX) : dram_code_i;
  assign dram_word = 32'h0000_1002 | {21'b0, code_c, 8'b0};

  sysctl_decode #(.NREGS(NUM_REGS)) u_dec (
    .sel_i (sel_i),
    .wr_i  (wr_i),
    .idx_i (idx),
    .we_o  (we),
    .err_o (err_d)
  );

  for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_reg
    if (g == int'(IDX_STRAP)) begin : g_strap
      assign rst_val[g] = strap_i;
    end else if (g == int'(IDX_MDIS)) begin : g_mdis
      assign rst_val[g] = mod_dis_i;
    end else if (g == int'(IDX_DRAM)) begin : g_dram
      assign rst_val[g] = dram_word;
    end else begin : g_const
      assign rst_val[g] = default_of(g);
    end

    sysctl_reg #(.POLICY(policy_of(g))) u_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rst_val_i (rst_val[g]),
      .we_i      (we[g]),
      .wdata_i   (wdata_i),
      .q_o       (reg_q[g])
    );
  end

  sysctl_rdmux #(.NREGS(NUM_REGS)) u_rd (
    .regs_i (reg_q),
    .idx_i  (idx),
    .data_o (rd_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= err_d;
      if (sel_i && !wr_i) rdata_o <= rd_d;
    end
  end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
  import sysctl_pkg::*;
(
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            sel_i,
  input logic                            wr_i,
  input logic [ADDR_W-1:0]               addr_i,
  input logic [DATA_W-1:0]               rdata_o,
  input logic                            err_o,
  input logic [NUM_REGS-1:0][DATA_W-1:0] reg_q
);
  logic in_rng;
  logic ro_tgt;

  assign in_rng = addr_i[ADDR_W-1:2] < IDX_W'(NUM_REGS);
  assign ro_tgt = (addr_i[ADDR_W-1:2] == IDX_W'(0)) ||
                  (addr_i[ADDR_W-1:2] == IDX_W'(1)) ||
                  (addr_i[ADDR_W-1:2] == IDX_W'(16));

  a_r1_oor_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i && !in_rng) |=> (rdata_o == '0));

  a_r10_err_on_oor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !in_rng) |=> err_o);

  a_r10_err_on_ro_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && ro_tgt) |=> err_o);

  a_r10_no_err_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && (!in_rng || (wr_i && ro_tgt))) |=> !err_o);

  a_r3_ro_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(reg_q[0]) && $stable(reg_q[1]) && $stable(reg_q[16]));

  a_r4_w1c_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_q[27] & ~$past(reg_q[27])) == '0) && ((reg_q[53] & ~$past(reg_q[53])) == '0));

  a_r5_w1s_no_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(reg_q[28]) & ~reg_q[28]) == '0) && (($past(reg_q[31]) & ~reg_q[31]) == '0));
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .err_o   (err_o),
  .reg_q   (reg_q)
);

// File: tb/sysctl_regfile_test.sv
module sysctl_regfile_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o;
  logic [31:0] strap_i = '0;
  logic [31:0] mod_dis_i = '0;
  logic [2:0]  dram_code_i = '0;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mdl [0:81];

  sysctl_regfile uut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp,
                     input logic [11:0] off);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s off=0x%03h got=0x%08h exp=0x%08h", tag, off, got, exp);
    end
  endtask

  // 0 rw, 1 ro, 2 w1c, 3 w1s, 4 out of range
  function automatic int kind(input logic [11:0] off);
    if (off >= 12'h148) return 4;
    case (off)
      12'h000, 12'h004, 12'h040: return 1;
      12'h06C, 12'h0D4:          return 2;
      12'h070, 12'h07C:          return 3;
      default:                   return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rst(input logic [11:0] off, input logic [31:0] s,
                                          input logic [31:0] m, input int code);
    int c;
    c = (code > 4) ? 4 : code;
    case (off)
      12'h000: return 32'h04A92750;
      12'h004: return s;
      12'h010: return 32'h0000FFFF;
      12'h038: return 32'h00000003;
      12'h03C: return 32'h0000035E;
      12'h050: return 32'h0000004E;
      12'h060: return 32'h00080000;
      12'h06C: return 32'h80000000;
      12'h078: return 32'h000000C0;
      12'h07C: return m;
      12'h098: return 32'h5A00F3CF;
      12'h09C: return 32'h00001002 + 32'(c) * 256;
      12'h13C: return 32'h00000008;
      12'h140, 12'h144: return 32'h034730E4;
      default: return 32'h0;
    endcase
  endfunction

  task automatic do_reset(input logic [31:0] s, input logic [31:0] m, input logic [2:0] c);
    @(negedge clk_i);
    strap_i = s; mod_dis_i = m; dram_code_i = c;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic rd(input logic [11:0] off, output logic [31:0] d, output logic e);
    sel_i = 1'b1; wr_i = 1'b0; addr_i = off;
    @(negedge clk_i);
    sel_i = 1'b0;
    d = rdata_o; e = err_o;
  endtask

  task automatic wr(input logic [11:0] off, input logic [31:0] v, output logic e);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = off; wdata_i = v;
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b0;
    e = err_o;
  endtask

  task automatic read_sweep(input bit after_reset);
    logic [31:0] d;
    logic e;
    for (int i = 0; i < 1024; i++) begin
      logic [11:0] off;
      string tag;
      off = 12'(i * 4);
      rd(off, d, e);
      if (kind(off) == 4) tag = after_reset ? "R1" : "R2";
      else if (after_reset) tag = (off == 12'h004 || off == 12'h07C) ? "R7" :
                                  (off == 12'h09C) ? "R8" : "R6";
      else case (kind(off))
        1: tag = "R3";
        2: tag = "R4";
        3: tag = "R5";
        default: tag = "R9";
      endcase
      chk(tag, d, (kind(off) == 4) ? 32'h0 : mdl[i], off);
      chk("R10", {31'b0, e}, {31'b0, kind(off) == 4}, off);
    end
  endtask

  task automatic write_sweep(input logic [31:0] seed);
    logic e;
    for (int i = 0; i < 1024; i++) begin
      logic [11:0] off;
      logic [31:0] v;
      off = 12'(i * 4);
      v = seed ^ (32'(i) * 32'h01010101) ^ {32'(i) << 7};
      wr(off, v, e);
      chk("R10", {31'b0, e}, {31'b0, kind(off) == 4 || kind(off) == 1}, off);
      case (kind(off))
        0: mdl[i] = v;
        2: mdl[i] = mdl[i] & ~v;
        3: mdl[i] = mdl[i] | v;
        default: ;
      endcase
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic e;
    do_reset(32'hA5C3_0F11, 32'h0000_1234, 3'd2);
    chk("R1", rdata_o, 32'h0, 12'h000);
    chk("R10", {31'b0, err_o}, 32'h0, 12'h000);
    for (int i = 0; i < 82; i++) mdl[i] = exp_rst(12'(i * 4), 32'hA5C3_0F11, 32'h0000_1234, 2);
    read_sweep(1'b1);
    // R1: data holds when no read is issued
    repeat (3) @(negedge clk_i);
    chk("R1", rdata_o, 32'h0, 12'hFFC);

    write_sweep(32'h9E37_79B9);
    read_sweep(1'b0);
    write_sweep(32'h3C6E_F372);
    read_sweep(1'b0);

    // R2: out-of-range write leaves last word untouched
    wr(12'h148, 32'hFFFF_FFFF, e);
    rd(12'h144, d, e);
    chk("R2", d, mdl[81], 12'h144);
    rd(12'h148, d, e);
    chk("R2", d, 32'h0, 12'h148);

    // R7/R8: every DRAM code including clamped ones
    for (int c = 0; c < 8; c++) begin
      logic [31:0] s;
      s = 32'h0101_0101 * 32'(c + 1);
      do_reset(s, ~s, 3'(c));
      rd(12'h004, d, e);
      chk("R7", d, s, 12'h004);
      rd(12'h07C, d, e);
      chk("R7", d, ~s, 12'h07C);
      rd(12'h09C, d, e);
      chk("R8", d, exp_rst(12'h09C, s, ~s, c), 12'h09C);
      // input change after release must not move the word
      dram_code_i = 3'(7 - c);
      rd(12'h09C, d, e);
      chk("R8", d, exp_rst(12'h09C, s, ~s, c), 12'h09C);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule